// File: doc/BRIEF.md
# Complementary PWM Dead-Time Inserter

This block drives one high-side/low-side gate pair from a center-aligned up/down counter. A period value sets the length of the modulation cycle, and a duty value sets how long the high side would ideally conduct in each cycle. The duty is latched at the start of each period. In double-update mode it is also latched at the midpoint, where the counter turns around. Every turn-on edge is held back by a programmable dead time, while turn-off is immediate. As a result, the two gates are never on together and each conducts for its ideal time minus the dead time.

A duty latch at a boundary can flip the ideal state in the very cycle the new value takes effect, for example when entering full-off at the midpoint or full-on at the period start. In that case the outgoing gate is switched off at the boundary, and the incoming gate cannot take an earlier edge from the previous half-cycle. The block therefore puts the whole guard interval on the incoming turn-on edge and doubles it to twice the dead time. If the request for the delayed gate is withdrawn before its delay runs out, that gate stays off.

Top module: `pwm_deadtime_pair`

## Requirements
- R1: A synchronous reset holds both gates low, clears all pending turn-on delays, and restarts the counter. On the first clock after reset is released, the period and duty are latched and the counter begins its first period.
- R2: The half-period length H is max(1, floor(period/2)), and H is latched only at a period start. One modulation cycle lasts 2*H clocks: the counter goes up from 0 to H-1, then back down from H-1 to 0.
- R3: With latched duty D and count c, the ideal high-side state is on when c + floor(D/2) >= H. The ideal low side is the complement of the high side.
- R4: A gate turns off on the clock edge after its ideal state drops. On a normal edge, a gate turns on exactly DT clocks after the opposite gate turned off, where DT is the dead-time input.
- R5: The two gates are never high in the same cycle.
- R6: The duty input is latched at each period start. It is also latched at the midpoint only when the double-update input is 1. In single-update mode, a duty change takes effect at the next period start and not before.
- R7: A duty below 2 keeps the high gate off for the whole period. A duty of at least the period keeps the low gate off for the whole period.
- R8: When the ideal state flips in the first cycle after a duty latch, the turn-on is delayed by 2*DT clocks from the opposite gate's turn-off instead of DT. Entering full-on at the midpoint in double-update mode needs no flip and keeps the normal DT.
- R9: If a gate's ideal state drops before its turn-on delay expires, the gate stays off and its delay is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| periodIn | input | 12 | Modulation period in clocks, latched at period start |
| dutyIn | input | 12 | Ideal high-side on-time per period, in clocks |
| deadTime | input | 8 | Dead time in clocks |
| dblUpdate | input | 1 | 1 also latches duty at the counter midpoint |
| gateHi | output | 1 | High-side gate drive |
| gateLo | output | 1 | Low-side gate drive |

## Verification
The key coincidence is a duty latch at a boundary that flips the ideal state in the same cycle as a turn-on request. Here the normal dead-time timer and the emergency doubling meet on one edge. The bench provokes this by dropping the duty to zero in double-update mode just before a midpoint, and by raising it to full-on in single-update mode just before a period start. It judges the result with a cycle-accurate scoreboard and by measuring the gap between the opposite gate's turn-off and the delayed turn-on, which must be 2*DT. A contrasting case, full-on entered at the midpoint, must keep the plain DT gap.

// File: rtl/pwm_dt_pkg.sv
package pwm_dt_pkg;

  // Strobes from the counter sequencer to the gate datapath
  typedef struct packed {
    logic run;       // counter running, gates may be requested
    logic loadDuty;  // latch duty on this edge
    logic boundary;  // first cycle after a duty latch
  } pwmStrobe_t;

  localparam int NumSides = 2;  // index 0 high side, 1 low side

endpackage

// File: rtl/pwm_dt_ctrl.sv
module pwm_dt_ctrl
  import pwm_dt_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] periodIn,
  input  logic         dblUpdate,
  output logic [W-1:0] cnt,
  output logic [W-1:0] half,
  output pwmStrobe_t   strb
);

  logic         startQ, downQ, boundQ;
  logic [W-1:0] cntQ, halfQ, halfNew, halfRaw;
  logic         atMid, atEnd, loadNow;

  assign halfRaw = periodIn >> 1;
  assign halfNew = (halfRaw == '0) ? W'(1) : halfRaw;

  assign atMid   = !startQ && !downQ && (cntQ == halfQ - W'(1));
  assign atEnd   = !startQ && downQ && (cntQ == '0);
  assign loadNow = startQ || atEnd || (atMid && dblUpdate);

  always_ff @(posedge clk) begin
    if (rst) begin
      startQ <= 1'b1;
      downQ  <= 1'b0;
      boundQ <= 1'b0;
      cntQ   <= '0;
      halfQ  <= W'(1);
    end else begin
      boundQ <= loadNow;
      if (startQ || atEnd) begin
        startQ <= 1'b0;
        downQ  <= 1'b0;
        cntQ   <= '0;
        halfQ  <= halfNew;
      end else if (atMid) begin
        downQ <= 1'b1;
      end else if (downQ) begin
        cntQ <= cntQ - W'(1);
      end else begin
        cntQ <= cntQ + W'(1);
      end
    end
  end

  assign cnt           = cntQ;
  assign half          = halfQ;
  assign strb.run      = !startQ;
  assign strb.loadDuty = loadNow;
  assign strb.boundary = boundQ;

  // R2: count stays inside the latched half-period
  a_r2_count_range: assert property (@(posedge clk) disable iff (rst)
    !startQ |-> (cntQ < halfQ));

  // R6: a latch boundary only follows a turnaround or period start
  a_r6_boundary_pos: assert property (@(posedge clk) disable iff (rst)
    boundQ |-> (cntQ == '0 || cntQ == halfQ - W'(1)));

  // R2: direction flips only at the extremes
  a_r2_turnaround: assert property (@(posedge clk) disable iff (rst)
    (!startQ && $past(!startQ) && downQ != $past(downQ)) |->
      (cntQ == '0 || cntQ == halfQ - W'(1)));

endmodule

// File: rtl/pwm_dt_side.sv
module pwm_dt_side #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          want,
  input  logic          emerg,
  input  logic [DW-1:0] deadTime,
  output logic          gate
);

  localparam int TW = DW + 1;

  logic          gateQ, prevQ;
  logic [TW-1:0] timerQ, delay;

  assign delay = emerg ? {deadTime, 1'b0} : {1'b0, deadTime};

  always_ff @(posedge clk) begin
    if (rst) begin
      gateQ  <= 1'b0;
      prevQ  <= 1'b0;
      timerQ <= '0;
    end else begin
      prevQ <= want;
      if (!want) begin
        gateQ  <= 1'b0;
        timerQ <= '0;
      end else if (!prevQ) begin
        if (delay == '0) gateQ <= 1'b1;
        else timerQ <= delay - TW'(1);
      end else if (!gateQ) begin
        if (timerQ == '0) gateQ <= 1'b1;
        else timerQ <= timerQ - TW'(1);
      end
    end
  end

  assign gate = gateQ;

  // R1: reset forces the gate low
  a_r1_reset_off: assert property (@(posedge clk) rst |=> !gateQ);

  // R4: a gate only rises after its request was present
  a_r4_rise_needs_want: assert property (@(posedge clk) disable iff (rst)
    $rose(gateQ) |-> $past(want));

  // R9: a dropped request leaves the gate off
  a_r9_drop_off: assert property (@(posedge clk) disable iff (rst)
    !want |=> !gateQ);

  // R8: an emergency request with nonzero dead time is not granted at once
  a_r8_emerg_holds: assert property (@(posedge clk) disable iff (rst)
    (want && !prevQ && emerg && deadTime != '0) |=> !gateQ);

endmodule

// File: rtl/pwm_dt_datapath.sv
module pwm_dt_datapath
  import pwm_dt_pkg::*;
#(
  parameter int W  = 12,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  dutyIn,
  input  logic [DW-1:0] deadTime,
  input  logic [W-1:0]  cnt,
  input  logic [W-1:0]  half,
  input  pwmStrobe_t    strb,
  output logic          gateHi,
  output logic          gateLo
);

  logic [W-1:0]          dutyQ, dutyHalf;
  logic [W:0]            sum;
  logic                  cmpHi;
  logic [NumSides-1:0]   want, gates;

  always_ff @(posedge clk) begin
    if (rst) dutyQ <= '0;
    else if (strb.loadDuty) dutyQ <= dutyIn;
  end

  assign dutyHalf = dutyQ >> 1;
  assign sum      = {1'b0, cnt} + {1'b0, dutyHalf};
  assign cmpHi    = (sum >= {1'b0, half});
  assign want[0]  = strb.run && cmpHi;
  assign want[1]  = strb.run && !cmpHi;

  for (genvar s = 0; s < NumSides; s++) begin : g_side
    pwm_dt_side #(.DW(DW)) u_side (
      .clk      (clk),
      .rst      (rst),
      .want     (want[s]),
      .emerg    (strb.boundary),
      .deadTime (deadTime),
      .gate     (gates[s])
    );
  end

  assign gateHi = gates[0];
  assign gateLo = gates[1];

  // R3: the two requests are mutually exclusive
  a_r3_want_excl: assert property (@(posedge clk) disable iff (rst)
    $countones(want) <= 1);

endmodule

// File: rtl/pwm_deadtime_pair.sv
module pwm_deadtime_pair
  import pwm_dt_pkg::*;
#(
  parameter int W  = 12,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  periodIn,
  input  logic [W-1:0]  dutyIn,
  input  logic [DW-1:0] deadTime,
  input  logic          dblUpdate,
  output logic          gateHi,
  output logic          gateLo
);

  logic [W-1:0] cnt, half;
  pwmStrobe_t   strb;

  pwm_dt_ctrl #(.W(W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .periodIn  (periodIn),
    .dblUpdate (dblUpdate),
    .cnt       (cnt),
    .half      (half),
    .strb      (strb)
  );

  pwm_dt_datapath #(.W(W), .DW(DW)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .dutyIn   (dutyIn),
    .deadTime (deadTime),
    .cnt      (cnt),
    .half     (half),
    .strb     (strb),
    .gateHi   (gateHi),
    .gateLo   (gateLo)
  );

  // R5: shoot-through never occurs
  a_r5_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(gateHi && gateLo));

endmodule

// File: tb/tb_pwm_deadtime_pair.sv
`timescale 1ns/1ps
module tb_pwm_deadtime_pair;

  localparam int W  = 12;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [W-1:0]  periodIn = 12'd20;
  logic [W-1:0]  dutyIn = 12'd10;
  logic [DW-1:0] deadTime = 8'd3;
  logic          dblUpdate = 1'b0;
  logic          gateHi, gateLo;

  always #2.5 clk = ~clk;

  pwm_deadtime_pair #(.W(W), .DW(DW)) dut (
    .clk(clk), .rst(rst), .periodIn(periodIn), .dutyIn(dutyIn),
    .deadTime(deadTime), .dblUpdate(dblUpdate),
    .gateHi(gateHi), .gateLo(gateLo)
  );

  int errors = 0;
  int checks = 0;
  string curTag = "R1";

  bit [1:0] expQ[$];
  string    tagQ[$];

  // reference model state
  int  mP, mH, mDuty, mCnt, mDelay;
  bit  mStart, mBound, mLoad, mHiW;
  bit  mWant[2], mGate[2], mPrev[2];
  int  mTim[2];

  always @(posedge clk) begin
    if (rst) begin
      mStart = 1; mP = 0; mH = 1; mDuty = 0; mBound = 0;
      for (int s = 0; s < 2; s++) begin mGate[s] = 0; mTim[s] = 0; mPrev[s] = 0; end
    end else begin
      mCnt = (mP < mH) ? mP : 2*mH - 1 - mP;
      mHiW = !mStart && (mCnt + mDuty/2 >= mH);
      mWant[0] = mHiW;
      mWant[1] = !mStart && !mHiW;
      for (int s = 0; s < 2; s++) begin
        if (!mWant[s]) begin
          mGate[s] = 0; mTim[s] = 0;
        end else if (!mPrev[s]) begin
          mDelay = mBound ? 2*int'(deadTime) : int'(deadTime);
          if (mDelay == 0) mGate[s] = 1;
          else mTim[s] = mDelay - 1;
        end else if (!mGate[s]) begin
          if (mTim[s] == 0) mGate[s] = 1;
          else mTim[s] = mTim[s] - 1;
        end
        mPrev[s] = mWant[s];
      end
      mLoad = 0;
      if (mStart || mP == 2*mH - 1) begin
        mP = 0;
        mH = (int'(periodIn) / 2 < 1) ? 1 : int'(periodIn) / 2;
        mLoad = 1; mStart = 0;
      end else begin
        if (mP == mH - 1 && dblUpdate) mLoad = 1;
        mP = mP + 1;
      end
      if (mLoad) mDuty = int'(dutyIn);
      mBound = mLoad;
    end
    expQ.push_back({mGate[0], mGate[1]});
    tagQ.push_back(curTag);
  end

  // monitor statistics
  bit prevHi = 0, prevLo = 0;
  int sinceHiOff = 1000, sinceLoOff = 1000, sinceHiRise = 0;
  int lastHiGap = -1, lastLoGap = -1, hiPeriod = -1;
  int hiOnCnt = 0, loOnCnt = 0;

  always @(negedge clk) begin
    bit [1:0] e;
    string t;
    if (expQ.size() > 0) begin
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checks++;
      if ({gateHi, gateLo} !== e) begin
        errors++;
        $display("FAIL %s: gates hi/lo actual=%b%b expected=%b%b at %0t",
                 t, gateHi, gateLo, e[1], e[0], $time);
      end
    end
    checks++;
    if (gateHi && gateLo) begin
      errors++;
      $display("FAIL R5: overlap actual=11 expected=not both high at %0t", $time);
    end
    if (rst) begin
      sinceHiOff = 1000; sinceLoOff = 1000; sinceHiRise = 0;
    end else begin
      sinceHiOff  = (prevHi && !gateHi) ? 0 : sinceHiOff + 1;
      sinceLoOff  = (prevLo && !gateLo) ? 0 : sinceLoOff + 1;
      sinceHiRise = sinceHiRise + 1;
      if (gateHi && !prevHi) begin
        if (sinceLoOff < 1000) begin
          lastHiGap = sinceLoOff;
          checks++;
          if (sinceLoOff < int'(deadTime)) begin
            errors++;
            $display("FAIL R4: hi turn-on gap actual=%0d expected>=%0d", sinceLoOff, deadTime);
          end
        end
        hiPeriod = sinceHiRise; sinceHiRise = 0;
      end
      if (gateLo && !prevLo && sinceHiOff < 1000) begin
        lastLoGap = sinceHiOff;
        checks++;
        if (sinceHiOff < int'(deadTime)) begin
          errors++;
          $display("FAIL R4: lo turn-on gap actual=%0d expected>=%0d", sinceHiOff, deadTime);
        end
      end
    end
    if (gateHi) hiOnCnt++;
    if (gateLo) loOnCnt++;
    prevHi = gateHi; prevLo = gateLo;
  end

  task automatic runCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk) rst = 1'b1;
    runCycles(3);
    rst = 1'b0;
  endtask

  task automatic clearStats();
    hiOnCnt = 0; loOnCnt = 0;
  endtask

  task automatic checkEq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    // R1: reset state
    curTag = "R1";
    runCycles(4);
    checkEq("R1 hi during reset", int'(gateHi), 0);
    checkEq("R1 lo during reset", int'(gateLo), 0);
    rst = 1'b0;

    // R3 / R4: normal modulation, single update
    curTag = "R3";
    runCycles(60);
    checkEq("R4 normal hi gap", lastHiGap, 3);
    checkEq("R4 normal lo gap", lastLoGap, 3);
    dutyIn = 12'd6;  runCycles(60);
    dutyIn = 12'd14; runCycles(60);

    // R2: period changes
    curTag = "R2";
    periodIn = 12'd12; dutyIn = 12'd6; runCycles(60);
    checkEq("R2 period 12", hiPeriod, 12);
    periodIn = 12'd31; runCycles(90);
    checkEq("R2 period 31", hiPeriod, 30);
    periodIn = 12'd20; dutyIn = 12'd10;

    // R4: zero and larger dead time
    curTag = "R4";
    deadTime = 8'd0; doReset(); runCycles(60);
    checkEq("R4 zero dt gap", lastHiGap, 0);
    deadTime = 8'd5; doReset(); runCycles(60);
    checkEq("R4 dt5 gap", lastHiGap, 5);
    deadTime = 8'd3; doReset();

    // R6: duty changes at odd times, single then double update
    curTag = "R6";
    for (int i = 0; i < 20; i++) begin
      dutyIn = (i % 3 == 0) ? 12'd4 : (i % 3 == 1) ? 12'd16 : 12'd10;
      runCycles(7);
    end
    dblUpdate = 1'b1;
    for (int i = 0; i < 20; i++) begin
      dutyIn = (i % 3 == 0) ? 12'd16 : (i % 3 == 1) ? 12'd4 : 12'd12;
      runCycles(7);
    end
    dblUpdate = 1'b0;

    // R7: full-off and full-on
    curTag = "R7";
    dutyIn = 12'd0; runCycles(45); clearStats(); runCycles(60);
    checkEq("R7 full-off hi on cycles", hiOnCnt, 0);
    checkEq("R7 full-off lo active", int'(loOnCnt > 0), 1);
    dutyIn = 12'd20; runCycles(45); clearStats(); runCycles(60);
    checkEq("R7 full-on lo on cycles", loOnCnt, 0);
    dutyIn = 12'd4095; runCycles(45); clearStats(); runCycles(60);
    checkEq("R7 max duty lo on cycles", loOnCnt, 0);

    // R8: full-off entered at the midpoint, double update
    curTag = "R8";
    dutyIn = 12'd10; dblUpdate = 1'b1; doReset(); runCycles(25);
    dutyIn = 12'd0; runCycles(40);
    checkEq("R8 emergency lo gap", lastLoGap, 6);
    // R8: full-on entered at period start, single update
    dutyIn = 12'd10; dblUpdate = 1'b0; doReset(); runCycles(25);
    dutyIn = 12'd20; runCycles(50);
    checkEq("R8 emergency hi gap", lastHiGap, 6);
    // R8: full-on at the midpoint, double update, keeps normal dead time
    dutyIn = 12'd10; dblUpdate = 1'b1; doReset(); runCycles(25);
    dutyIn = 12'd20; runCycles(50);
    checkEq("R8 mid full-on hi gap", lastHiGap, 3);
    clearStats(); runCycles(40);
    checkEq("R8 mid full-on lo on cycles", loOnCnt, 0);
    dblUpdate = 1'b0;

    // R9: low window shorter than dead time never turns on
    curTag = "R9";
    deadTime = 8'd8; dutyIn = 12'd16; doReset(); clearStats(); runCycles(80);
    checkEq("R9 cancelled lo on cycles", loOnCnt, 0);
    checkEq("R9 hi still active", int'(hiOnCnt > 0), 1);

    runCycles(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule